// File: doc/BRIEF.md
# Protection Register Programmer

This block holds four byte-wide non-volatile protection registers and the logic that programs them. Programming only ever clears bits. Software first raises an arm bit in the control word. It then writes one to four register addresses with new data, in any order. Each write lands in a small staging buffer. A start request commits all staged entries at once after a programmable wait. Each staged register takes the AND of its old value and its staged byte. Registers that were not staged keep their contents.

While a commit is running, the block reports busy. All writes are dropped during that time, and reads of the protection registers return all ones. When the wait ends, the staged values are applied, the buffer empties, the arm bit drops and busy falls. A start with nothing staged does not raise busy; it only drops the arm bit. What each protection bit guards is decided elsewhere.

Top module: `prot_prog_top`

## Requirements
- R1: After reset all four protection registers read FFh, the control word reads 00h, the delay register reads 03h and `busy` is low.
- R2: A commit sets each staged register to its old value ANDed with its staged byte, so a bit that is 0 never returns to 1.
- R3: A register whose address was not staged in the current batch keeps its value across the commit.
- R4: Up to four distinct registers (addresses 0 to 3) can be staged in any address order and are all applied by one commit.
- R5: Staging the same address twice before a commit keeps only the last byte written; it does not take a second slot and the two bytes are not combined.
- R6: A start request (control write at address 4 with bit 0 = 1 and bit 1 = 1) with at least one entry staged raises `busy` at the next edge. `busy` stays high for delay+1 cycles, where delay is the value at address 5. When it falls, the arm bit (control bit 1) reads 0.
- R7: A start request with nothing staged leaves `busy` low, clears the arm bit at the next edge and changes no register.
- R8: While `busy` is high, every write (staging, control or delay) is ignored.
- R9: Writes to addresses 0 to 3 while the arm bit is 0 are ignored. Writing the control word with bit 1 = 0 discards any staged entries.
- R10: While `busy` is high, a read of addresses 0 to 3 returns FFh.
- R11: `rd_data` is registered and shows, one cycle after `rd_addr` is presented, this value: for addresses 0 to 3, the register; for address 4, the control word (bit 1 = arm, bit 2 = busy); for address 5, the delay byte; for anything else, 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Registered read data |
| busy | output | 1 | Commit in progress |

## Verification
The hardest state to reach from the ports is a commit in flight with traffic still arriving. That traffic includes staging, control and delay writes, and reads of the registers being programmed. The bench sets a long commit delay and then issues all of these during the busy window. After busy falls, it reads back each register and the delay. A second hard case is a batch that revisits an address after all four slots hold distinct entries. The bench fills every address in a scrambled order and then rewrites one of them.

// File: rtl/prot_prog_pkg.sv
package prot_prog_pkg;

  // Control word bit positions (shared by decode and read-back)
  localparam int unsigned CTRL_START_BIT = 0;
  localparam int unsigned CTRL_ARM_BIT   = 1;
  localparam int unsigned CTRL_BUSY_BIT  = 2;

  typedef enum logic {
    CMT_IDLE = 1'b0,
    CMT_WAIT = 1'b1
  } cmt_state_e;

endpackage

// File: rtl/prot_stage_buf.sv
module prot_stage_buf #(
  parameter int NREG  = 4,
  parameter int DW    = 8,
  parameter int IDX_W = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [IDX_W-1:0]         widx,
  input  logic [DW-1:0]            wdata,
  input  logic                     flush,
  output logic [NREG-1:0][DW-1:0]  mask,
  output logic                     any_valid
);

  logic [NREG-1:0]            slot_v;
  logic [NREG-1:0][IDX_W-1:0] slot_idx;
  logic [NREG-1:0][DW-1:0]    slot_d;
  logic [NREG-1:0]            hit;
  logic [NREG-1:0]            free;
  logic [IDX_W-1:0]           tgt;
  logic                       tgt_ok;

  genvar s;
  generate
    for (s = 0; s < NREG; s++) begin : g_slot
      assign hit[s]  = slot_v[s] && (slot_idx[s] == widx);
      assign free[s] = !slot_v[s];
    end
  endgenerate

  // Slot choice: a matching slot wins, else the lowest free slot
  always_comb begin
    tgt    = '0;
    tgt_ok = 1'b0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (free[i]) begin
        tgt    = IDX_W'(i);
        tgt_ok = 1'b1;
      end
    end
    for (int i = 0; i < NREG; i++) begin
      if (hit[i]) begin
        tgt    = IDX_W'(i);
        tgt_ok = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      slot_v <= '0;
    end else if (we && tgt_ok) begin
      slot_v[tgt]   <= 1'b1;
      slot_idx[tgt] <= widx;
      slot_d[tgt]   <= wdata;
    end
  end

  // Per-register clear mask; all ones where nothing is staged
  always_comb begin
    for (int r = 0; r < NREG; r++) begin
      mask[r] = '1;
      for (int i = 0; i < NREG; i++) begin
        if (slot_v[i] && (slot_idx[i] == IDX_W'(r))) begin
          mask[r] = mask[r] & slot_d[i];
        end
      end
    end
  end

  assign any_valid = |slot_v;

  // R5
  dup_slot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit));

  // R4
  stage_room_chk: assert property (@(posedge clk) disable iff (rst)
    we |-> tgt_ok);

endmodule

// File: rtl/prot_commit_fsm.sv
module prot_commit_fsm
  import prot_prog_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [CW-1:0] dly,
  output logic          busy,
  output logic          done
);

  cmt_state_e    state;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= CMT_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        CMT_IDLE: begin
          if (start) begin
            state <= CMT_WAIT;
            cnt   <= dly;
          end
        end
        CMT_WAIT: begin
          if (cnt == '0) begin
            state <= CMT_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= CMT_IDLE;
      endcase
    end
  end

  assign busy = (state == CMT_WAIT);
  assign done = busy && (cnt == '0);

  // R6
  hold_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && (cnt != '0)) |=> busy);

  // R6
  done_end_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy);

  // R8
  start_idle_chk: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);

endmodule

// File: rtl/prot_reg_bank.sv
module prot_reg_bank #(
  parameter int NREG = 4,
  parameter int DW   = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    apply,
  input  logic [NREG-1:0][DW-1:0] mask,
  output logic [NREG-1:0][DW-1:0] regs
);

  genvar r;
  generate
    for (r = 0; r < NREG; r++) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          regs[r] <= '1;
        end else if (apply) begin
          regs[r] <= regs[r] & mask[r];
        end
      end
    end
  endgenerate

  // R2
  no_set_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((regs & ~$past(regs)) == '0));

  // R3
  keep_chk: assert property (@(posedge clk) disable iff (rst)
    !apply |=> $stable(regs));

endmodule

// File: rtl/prot_prog_top.sv
module prot_prog_top
  import prot_prog_pkg::*;
#(
  parameter int NREG    = 4,
  parameter int DW      = 8,
  parameter int DLY_RST = 3,
  parameter int AW      = $clog2(NREG + 2)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          busy
);

  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;
  localparam logic [AW-1:0] CTRL_ADDR = AW'(NREG);
  localparam logic [AW-1:0] DLY_ADDR  = AW'(NREG + 1);

  logic                    arm_q;
  logic [DW-1:0]           dly_q;
  logic [DW-1:0]           rd_q;
  logic [DW-1:0]           ctrl_word;
  logic [NREG-1:0][DW-1:0] mask;
  logic [NREG-1:0][DW-1:0] regs;
  logic                    any_valid;
  logic                    done;
  logic                    wr_is_reg;
  logic                    stage_we;
  logic                    ctrl_we;
  logic                    dly_we;
  logic                    new_arm;
  logic                    start_req;
  logic                    start_go;
  logic                    start_empty;
  logic                    flush;

  // Write decode; every write is dropped while busy
  assign wr_is_reg   = (wr_addr < AW'(NREG));
  assign stage_we    = wr_en && !busy && wr_is_reg && arm_q;
  assign ctrl_we     = wr_en && !busy && (wr_addr == CTRL_ADDR);
  assign dly_we      = wr_en && !busy && (wr_addr == DLY_ADDR);
  assign new_arm     = wr_data[CTRL_ARM_BIT];
  assign start_req   = ctrl_we && wr_data[CTRL_START_BIT] && new_arm;
  assign start_go    = start_req && any_valid;
  assign start_empty = start_req && !any_valid;
  assign flush       = done || (ctrl_we && !new_arm) || start_empty;

  prot_stage_buf #(
    .NREG  (NREG),
    .DW    (DW),
    .IDX_W (IDX_W)
  ) stage_i (
    .clk       (clk),
    .rst       (rst),
    .we        (stage_we),
    .widx      (wr_addr[IDX_W-1:0]),
    .wdata     (wr_data),
    .flush     (flush),
    .mask      (mask),
    .any_valid (any_valid)
  );

  prot_commit_fsm #(
    .CW (DW)
  ) fsm_i (
    .clk   (clk),
    .rst   (rst),
    .start (start_go),
    .dly   (dly_q),
    .busy  (busy),
    .done  (done)
  );

  prot_reg_bank #(
    .NREG (NREG),
    .DW   (DW)
  ) bank_i (
    .clk   (clk),
    .rst   (rst),
    .apply (done),
    .mask  (mask),
    .regs  (regs)
  );

  // Arm bit: self-clears on completion or on an empty start
  always_ff @(posedge clk) begin
    if (rst) begin
      arm_q <= 1'b0;
    end else if (done) begin
      arm_q <= 1'b0;
    end else if (ctrl_we) begin
      arm_q <= new_arm && !start_empty;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dly_q <= DW'(DLY_RST);
    end else if (dly_we) begin
      dly_q <= wr_data;
    end
  end

  always_comb begin
    ctrl_word                = '0;
    ctrl_word[CTRL_ARM_BIT]  = arm_q;
    ctrl_word[CTRL_BUSY_BIT] = busy;
  end

  // Registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
    end else if (rd_addr < AW'(NREG)) begin
      rd_q <= busy ? '1 : regs[rd_addr[IDX_W-1:0]];
    end else if (rd_addr == CTRL_ADDR) begin
      rd_q <= ctrl_word;
    end else if (rd_addr == DLY_ADDR) begin
      rd_q <= dly_q;
    end else begin
      rd_q <= '0;
    end
  end

  assign rd_data = rd_q;

  // R7
  empty_start_chk: assert property (@(posedge clk) disable iff (rst)
    start_empty |=> (!busy && !arm_q));

  // R9
  desel_flush_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_we && !new_arm) |=> !any_valid);

  // R8
  busy_dly_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && wr_en) |=> $stable(dly_q));

  // R10
  busy_rd_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && (rd_addr < AW'(NREG))) |=> (rd_data == '1));

  // R6
  arm_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !arm_q);

endmodule

// File: tb/prot_prog_top_tb_top.sv
module prot_prog_top_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       busy;

  int    n_chk = 0;
  int    n_err = 0;
  bit    finished = 1'b0;
  string phase = "R1";

  // Reference model state
  logic [7:0] m_reg [4];
  bit         m_sv  [4];
  logic [7:0] m_sd  [4];
  bit         m_arm, m_busy;
  int         m_cnt;
  logic [7:0] m_dly, m_rd, nrd;
  bit         any;

  always #4 clk = ~clk;   // 125 MHz

  prot_prog_top dut_i (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .busy    (busy)
  );

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 4; i++) begin
        m_reg[i] = 8'hFF; m_sv[i] = 0; m_sd[i] = 8'h00;
      end
      m_arm = 0; m_busy = 0; m_cnt = 0; m_dly = 8'd3; m_rd = 8'h00;
    end else begin
      if (rd_addr < 3'd4)       nrd = m_busy ? 8'hFF : m_reg[rd_addr[1:0]];
      else if (rd_addr == 3'd4) nrd = {5'b0, m_busy, m_arm, 1'b0};
      else if (rd_addr == 3'd5) nrd = m_dly;
      else                      nrd = 8'h00;
      if (m_busy) begin
        if (m_cnt == 0) begin
          for (int i = 0; i < 4; i++) begin
            if (m_sv[i]) m_reg[i] = m_reg[i] & m_sd[i];
            m_sv[i] = 0;
          end
          m_busy = 0; m_arm = 0;
        end else begin
          m_cnt = m_cnt - 1;
        end
      end else if (wr_en) begin
        if (wr_addr < 3'd4) begin
          if (m_arm) begin m_sv[wr_addr[1:0]] = 1; m_sd[wr_addr[1:0]] = wr_data; end
        end else if (wr_addr == 3'd4) begin
          any = 0;
          for (int i = 0; i < 4; i++) any = any | m_sv[i];
          if (wr_data[0] && wr_data[1]) begin
            if (any) begin m_busy = 1; m_cnt = int'(m_dly); m_arm = 1; end
            else m_arm = 0;
          end else begin
            m_arm = wr_data[1];
            if (!wr_data[1]) for (int i = 0; i < 4; i++) m_sv[i] = 0;
          end
        end else if (wr_addr == 3'd5) begin
          m_dly = wr_data;
        end
      end
      m_rd = nrd;
    end
  end

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !finished) begin
      n_chk++;
      if (rd_data !== m_rd || busy !== m_busy) begin
        n_err++;
        $display("FAIL %s model: actual rd=%h busy=%b expected rd=%h busy=%b",
                 phase, rd_data, busy, m_rd, m_busy);
      end
    end
  end

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string req);
    rd_addr = a;
    @(negedge clk);
    chk(rd_data, exp, req);
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    int n;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 / R11: reset state and read map
    chk({7'b0, busy}, 8'h00, "R1");
    rd(3'd0, 8'hFF, "R1"); rd(3'd1, 8'hFF, "R1");
    rd(3'd2, 8'hFF, "R1"); rd(3'd3, 8'hFF, "R1");
    rd(3'd4, 8'h00, "R1"); rd(3'd5, 8'h03, "R1");
    rd(3'd7, 8'h00, "R11");

    // R4, R2, R3, R6: out-of-order batch of two
    phase = "R4";
    wr(3'd4, 8'h02);
    rd(3'd4, 8'h02, "R11");
    wr(3'd2, 8'hF0); wr(3'd0, 8'h3C);
    wr(3'd4, 8'h03);
    wait_idle(n);
    chk(8'(n), 8'd4, "R6");
    rd(3'd4, 8'h00, "R6");
    rd(3'd0, 8'h3C, "R4"); rd(3'd2, 8'hF0, "R4");
    rd(3'd1, 8'hFF, "R3"); rd(3'd3, 8'hFF, "R3");

    // R2: AND semantics, ones never restored
    phase = "R2";
    wr(3'd4, 8'h02); wr(3'd0, 8'h0F); wr(3'd2, 8'hFF); wr(3'd4, 8'h03);
    wait_idle(n);
    rd(3'd0, 8'h0C, "R2"); rd(3'd2, 8'hF0, "R2");

    // R5: all four addresses scrambled, then a rewrite of one
    phase = "R5";
    wr(3'd4, 8'h02);
    wr(3'd3, 8'h00); wr(3'd1, 8'h55); wr(3'd0, 8'hFF); wr(3'd2, 8'hFF);
    wr(3'd3, 8'hA5);
    wr(3'd4, 8'h03);
    wait_idle(n);
    rd(3'd3, 8'hA5, "R5"); rd(3'd1, 8'h55, "R4");
    rd(3'd0, 8'h0C, "R4"); rd(3'd2, 8'hF0, "R4");

    // R7: empty start
    phase = "R7";
    wr(3'd4, 8'h02);
    wr(3'd4, 8'h03);
    chk({7'b0, busy}, 8'h00, "R7");
    rd(3'd4, 8'h00, "R7");
    rd(3'd1, 8'h55, "R7");

    // R9: staging without arm, and discard on disarm
    phase = "R9";
    wr(3'd1, 8'h00);
    wr(3'd4, 8'h02); wr(3'd4, 8'h03);
    chk({7'b0, busy}, 8'h00, "R9");
    rd(3'd1, 8'h55, "R9");
    wr(3'd4, 8'h02); wr(3'd1, 8'h00); wr(3'd4, 8'h00);
    wr(3'd4, 8'h02); wr(3'd4, 8'h03);
    chk({7'b0, busy}, 8'h00, "R9");
    rd(3'd1, 8'h55, "R9");

    // R8, R10: traffic during a long commit
    phase = "R8";
    wr(3'd5, 8'h0A);
    rd(3'd5, 8'h0A, "R11");
    wr(3'd4, 8'h02); wr(3'd0, 8'h08); wr(3'd4, 8'h03);
    wr(3'd2, 8'h00); wr(3'd5, 8'h01); wr(3'd4, 8'h00);
    rd(3'd0, 8'hFF, "R10");
    chk({7'b0, busy}, 8'h01, "R8");
    wait_idle(n);
    rd(3'd5, 8'h0A, "R8"); rd(3'd2, 8'hF0, "R8");
    rd(3'd0, 8'h08, "R8"); rd(3'd4, 8'h00, "R8");

    // R6: zero delay gives a single busy cycle
    phase = "R6";
    wr(3'd5, 8'h00);
    wr(3'd4, 8'h02); wr(3'd1, 8'h0F); wr(3'd4, 8'h03);
    wait_idle(n);
    chk(8'(n), 8'd1, "R6");
    rd(3'd1, 8'h05, "R2");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule